// File: doc/BRIEF.md
# Dual-Accumulator MAC Engine

This block is a fixed-point multiply-accumulate datapath with two wide accumulators, A and B. A command supplies two 16-bit operands, an operation code, a target accumulator and the arithmetic mode bits. The engine first extends the operands into a shared 17x17-bit signed multiplier. Depending on the mode, it then doubles the product for fractional arithmetic. The result is combined with the target accumulator in a 41-bit adder, and the new value is written back. Before the write, the value is either clamped or wrapped, according to that accumulator's saturation setting.

A small sequencer handles each command in three states. ST_IDLE accepts a command: on op_valid it captures the command and moves to ST_MULT. ST_MULT registers the product and always moves to ST_ACC. ST_ACC writes the accumulator and always returns to ST_IDLE. While the sequencer is outside ST_IDLE, `busy` is high and command strobes are ignored.

A readout port turns either accumulator into a 16-bit word. It rounds the value conventionally or to even, and can optionally saturate the result to the 16-bit signed range. The readout is combinational on the stored accumulators.

Top module: `mac_engine`

## Requirements
- R1: After reset, both accumulators and all four overflow flags are zero, `busy` is low and `rd_data` is zero.
- R2: A command is accepted only when op_valid is high while `busy` is low. `busy` is then high for exactly two cycles, and the accumulator holds its new value in the first cycle after `busy` falls. op_valid while busy is ignored. Operands and the mode bits frac_mode, signed_mode, sat_en_a, sat_en_b and sat_super are sampled only at acceptance.
- R3: With signed_mode=1 each operand is sign-extended to 17 bits, and with signed_mode=0 it is zero-extended. The product is the exact signed product of the two 17-bit values.
- R4: With frac_mode=1 the product is shifted left by one bit, and with frac_mode=0 it is used as is. The product is always sign-extended before it is combined.
- R5: Opcode encodings: 0 CLR (acc=0), 1 MPY (acc=p), 2 MPYN (acc=-p), 3 MAC (acc+=p), 4 MSC (acc-=p), 7 SQR (acc=x*x).
- R6: Opcode 5 ED sets acc to (x-y) squared, and opcode 6 EDAC adds (x-y) squared to acc. The difference is formed from the extended operands.
- R7: Opcode 9 ADD sets the target to A+B. Opcode 10 SUB sets the target to target minus the other accumulator. Opcode 11 NEG sets the target to its own negation. x and y have no effect on these three.
- R8: Opcode 8 and codes 12 to 15 change neither accumulator nor any flag.
- R9: When the target's saturation enable is set, sat_super=0 clamps the result to the signed 32-bit range and sat_super=1 clamps it to the signed 40-bit range. When the enable is clear, the result wraps to 40 bits.
- R10: On every write, the target's ov_lo flag is set if the exact result lies outside the signed 32-bit range, and its ov_hi flag is set if it lies outside the signed 40-bit range. Both flags are taken before saturation.
- R11: rd_data is taken from accumulator B when rd_sel=1 and from A otherwise. With rnd_convergent=0 it is floor((acc+0x8000)/65536).
- R12: With rnd_convergent=1, a low word of exactly 0x8000 rounds to the even neighbour. Every other low word rounds as in R11.
- R13: With sat_en_rd=1, a rounded value outside the 16-bit signed range reads as 0x7FFF or 0x8000. With sat_en_rd=0, the low 16 bits of the rounded value are output.
- R14: acc_sel (1 = B) selects the target, and the other accumulator and its flags are never altered by the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 4 | Operation code (R5 to R8) |
| acc_sel | input | 1 | Target accumulator, 1 = B |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| frac_mode | input | 1 | 1 = fractional product doubling |
| signed_mode | input | 1 | 1 = signed operands |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_super | input | 1 | 1 = clamp at 40 bits, 0 = at 32 bits |
| rd_sel | input | 1 | Readout source, 1 = B |
| rnd_convergent | input | 1 | 1 = round half to even |
| sat_en_rd | input | 1 | Readout saturation enable |
| busy | output | 1 | Command in progress |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ov_a_lo | output | 1 | A exceeded 32-bit range on last write |
| ov_a_hi | output | 1 | A exceeded 40-bit range on last write |
| ov_b_lo | output | 1 | B exceeded 32-bit range on last write |
| ov_b_hi | output | 1 | B exceeded 40-bit range on last write |
| rd_data | output | 16 | Rounded, optionally saturated readout |

## Verification
The bench builds the engine with its defaults, DATA_W=16 and ACC_W=40. At these widths every product and sum fits exactly in a 64-bit integer, so the reference can compute each result directly and compare it against the design. The eight guard bits above the 32-bit point can be overrun in about a dozen commands by chaining ADD between the two accumulators. This brings both the 40-bit flag and the super-saturation clamp within reach, alongside random mixes of every opcode, mode bit and rounding setting. The directed cases cover ties at 0x8000 on both parities, the most negative fractional square and strobes issued while busy.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [3:0] {
        OP_CLR    = 4'd0,
        OP_MPY    = 4'd1,
        OP_MPYN   = 4'd2,
        OP_MAC    = 4'd3,
        OP_MSC    = 4'd4,
        OP_ED     = 4'd5,
        OP_EDAC   = 4'd6,
        OP_SQR    = 4'd7,
        OP_MOVSAC = 4'd8,
        OP_ADD    = 4'd9,
        OP_SUB    = 4'd10,
        OP_NEG    = 4'd11
    } mac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MULT = 2'd1,
        ST_ACC  = 2'd2
    } mac_state_e;

    typedef struct packed {
        mac_op_e op;
        logic    sel_b;
        logic    frac;
        logic    sgn;
        logic    sat_a;
        logic    sat_b;
        logic    super_sat;
    } mac_cmd_t;

endpackage

// File: rtl/mac_mul_unit.sv
module mac_mul_unit
    import mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  mac_op_e           op,
    input  logic              sgn,
    input  logic              frac,
    output logic [ACC_W-1:0]  prod
);
    localparam int EXT_W  = DATA_W + 1;
    localparam int PROD_W = 2 * EXT_W;
    localparam int PAD_W  = ACC_W - PROD_W - 1;

    logic signed [EXT_W-1:0]  x_ext;
    logic signed [EXT_W-1:0]  y_ext;
    logic signed [EXT_W-1:0]  diff;
    logic signed [EXT_W-1:0]  mul_a;
    logic signed [EXT_W-1:0]  mul_b;
    logic signed [PROD_W-1:0] raw;
    logic        [PROD_W:0]   scaled;

    always_comb begin
        x_ext = {sgn & x[DATA_W-1], x};
        y_ext = {sgn & y[DATA_W-1], y};
        diff  = x_ext - y_ext;
        unique case (op)
            OP_ED, OP_EDAC: begin
                mul_a = diff;
                mul_b = diff;
            end
            OP_SQR: begin
                mul_a = x_ext;
                mul_b = x_ext;
            end
            default: begin
                mul_a = x_ext;
                mul_b = y_ext;
            end
        endcase
        raw    = mul_a * mul_b;
        scaled = frac ? {raw, 1'b0} : {raw[PROD_W-1], raw};
        prod   = {{PAD_W{scaled[PROD_W]}}, scaled};
    end

endmodule

// File: rtl/mac_acc_update.sv
module mac_acc_update
    import mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  mac_op_e          op,
    input  logic [ACC_W-1:0] acc_t,
    input  logic [ACC_W-1:0] acc_o,
    input  logic [ACC_W-1:0] prod,
    input  logic             sat_en,
    input  logic             super_sat,
    output logic [ACC_W-1:0] acc_new,
    output logic             wr_en,
    output logic             ov_lo,
    output logic             ov_hi
);
    localparam int SUM_W = ACC_W + 1;
    localparam int NRM_W = 2 * DATA_W;
    localparam int TOP_W = SUM_W - NRM_W + 1;

    localparam logic [ACC_W-1:0] MAX_NRM = {{(ACC_W-NRM_W+1){1'b0}}, {(NRM_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_NRM = {{(ACC_W-NRM_W+1){1'b1}}, {(NRM_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] MAX_SUP = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_SUP = {1'b1, {(ACC_W-1){1'b0}}};

    logic [SUM_W-1:0] t_ext;
    logic [SUM_W-1:0] o_ext;
    logic [SUM_W-1:0] p_ext;
    logic [SUM_W-1:0] sum;
    logic [TOP_W-1:0] top_bits;
    logic             neg;

    always_comb begin
        t_ext = {acc_t[ACC_W-1], acc_t};
        o_ext = {acc_o[ACC_W-1], acc_o};
        p_ext = {prod[ACC_W-1], prod};
        wr_en = 1'b1;
        unique case (op)
            OP_CLR:                 sum = '0;
            OP_MPY, OP_ED, OP_SQR:  sum = p_ext;
            OP_MPYN:                sum = -p_ext;
            OP_MAC, OP_EDAC:        sum = t_ext + p_ext;
            OP_MSC:                 sum = t_ext - p_ext;
            OP_ADD:                 sum = t_ext + o_ext;
            OP_SUB:                 sum = t_ext - o_ext;
            OP_NEG:                 sum = -t_ext;
            default: begin
                sum   = t_ext;
                wr_en = 1'b0;
            end
        endcase

        neg      = sum[SUM_W-1];
        top_bits = sum[SUM_W-1:NRM_W-1];
        ov_hi    = sum[SUM_W-1] != sum[ACC_W-1];
        ov_lo    = !((&top_bits) || !(|top_bits));

        if (!sat_en) begin
            acc_new = sum[ACC_W-1:0];
        end else if (super_sat) begin
            acc_new = ov_hi ? (neg ? MIN_SUP : MAX_SUP) : sum[ACC_W-1:0];
        end else begin
            acc_new = ov_lo ? (neg ? MIN_NRM : MAX_NRM) : sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/mac_round_unit.sv
module mac_round_unit #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic              convergent,
    input  logic              sat_en,
    output logic [DATA_W-1:0] rd
);
    localparam int HI_W  = ACC_W - DATA_W + 1;
    localparam int CHK_W = HI_W - DATA_W + 1;

    localparam logic [DATA_W-1:0] RD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] RD_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic             tie;
    logic             inc;
    logic [HI_W-1:0]  hi;
    logic [CHK_W-1:0] chk;
    logic             fits;

    always_comb begin
        tie  = acc[DATA_W-1] && (acc[DATA_W-2:0] == '0);
        inc  = acc[DATA_W-1] && !(convergent && tie && !acc[DATA_W]);
        hi   = {acc[ACC_W-1], acc[ACC_W-1:DATA_W]} + {{(HI_W-1){1'b0}}, inc};
        chk  = hi[HI_W-1:DATA_W-1];
        fits = (&chk) || !(|chk);
        if (sat_en && !fits) begin
            rd = hi[HI_W-1] ? RD_MIN : RD_MAX;
        end else begin
            rd = hi[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/mac_engine.sv
module mac_engine
    import mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              acc_sel,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic              frac_mode,
    input  logic              signed_mode,
    input  logic              sat_en_a,
    input  logic              sat_en_b,
    input  logic              sat_super,
    input  logic              rd_sel,
    input  logic              rnd_convergent,
    input  logic              sat_en_rd,
    output logic              busy,
    output logic [ACC_W-1:0]  acc_a,
    output logic [ACC_W-1:0]  acc_b,
    output logic              ov_a_lo,
    output logic              ov_a_hi,
    output logic              ov_b_lo,
    output logic              ov_b_hi,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NUM_ACC = 2;

    mac_state_e        state_q;
    mac_state_e        state_d;
    logic              cap_en;
    logic              prod_en;
    logic              acc_en;

    mac_cmd_t          cmd_q;
    logic [DATA_W-1:0] x_q;
    logic [DATA_W-1:0] y_q;
    logic [ACC_W-1:0]  prod_d;
    logic [ACC_W-1:0]  prod_q;

    logic [ACC_W-1:0]  acc_q   [NUM_ACC];
    logic              ovlo_q  [NUM_ACC];
    logic              ovhi_q  [NUM_ACC];

    logic [ACC_W-1:0]  acc_tgt;
    logic [ACC_W-1:0]  acc_oth;
    logic              sat_sel;
    logic [ACC_W-1:0]  acc_new;
    logic              wr_en;
    logic              ov_lo;
    logic              ov_hi;
    logic [ACC_W-1:0]  rd_src;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid) state_d = ST_MULT;
            ST_MULT: state_d = ST_ACC;
            ST_ACC:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state decoded controls
    always_comb begin
        busy    = (state_q != ST_IDLE);
        cap_en  = (state_q == ST_IDLE) && op_valid;
        prod_en = (state_q == ST_MULT);
        acc_en  = (state_q == ST_ACC);
    end

    // command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            x_q   <= '0;
            y_q   <= '0;
        end else if (cap_en) begin
            cmd_q.op        <= mac_op_e'(op_code);
            cmd_q.sel_b     <= acc_sel;
            cmd_q.frac      <= frac_mode;
            cmd_q.sgn       <= signed_mode;
            cmd_q.sat_a     <= sat_en_a;
            cmd_q.sat_b     <= sat_en_b;
            cmd_q.super_sat <= sat_super;
            x_q             <= x_in;
            y_q             <= y_in;
        end
    end

    mac_mul_unit #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) u_mul (
        .x    (x_q),
        .y    (y_q),
        .op   (cmd_q.op),
        .sgn  (cmd_q.sgn),
        .frac (cmd_q.frac),
        .prod (prod_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (prod_en) begin
            prod_q <= prod_d;
        end
    end

    always_comb begin
        acc_tgt = cmd_q.sel_b ? acc_q[1] : acc_q[0];
        acc_oth = cmd_q.sel_b ? acc_q[0] : acc_q[1];
        sat_sel = cmd_q.sel_b ? cmd_q.sat_b : cmd_q.sat_a;
    end

    mac_acc_update #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) u_upd (
        .op        (cmd_q.op),
        .acc_t     (acc_tgt),
        .acc_o     (acc_oth),
        .prod      (prod_q),
        .sat_en    (sat_sel),
        .super_sat (cmd_q.super_sat),
        .acc_new   (acc_new),
        .wr_en     (wr_en),
        .ov_lo     (ov_lo),
        .ov_hi     (ov_hi)
    );

    // accumulator banks
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[g]  <= '0;
                ovlo_q[g] <= 1'b0;
                ovhi_q[g] <= 1'b0;
            end else if (acc_en && wr_en && (cmd_q.sel_b == 1'(g))) begin
                acc_q[g]  <= acc_new;
                ovlo_q[g] <= ov_lo;
                ovhi_q[g] <= ov_hi;
            end
        end
    end

    always_comb begin
        acc_a   = acc_q[0];
        acc_b   = acc_q[1];
        ov_a_lo = ovlo_q[0];
        ov_a_hi = ovhi_q[0];
        ov_b_lo = ovlo_q[1];
        ov_b_hi = ovhi_q[1];
        rd_src  = rd_sel ? acc_q[1] : acc_q[0];
    end

    mac_round_unit #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) u_rnd (
        .acc        (rd_src),
        .convergent (rnd_convergent),
        .sat_en     (sat_en_rd),
        .rd         (rd_data)
    );

endmodule

// File: rtl/mac_engine_chk.sv
module mac_engine_chk
    import mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             busy,
    input mac_state_e       state_q,
    input mac_op_e          c_op,
    input logic             c_sel_b,
    input logic             c_sat_a,
    input logic             c_super,
    input logic [ACC_W-1:0] acc_a,
    input logic [ACC_W-1:0] acc_b
);
    localparam int NRM_W = 2 * DATA_W;

    logic writes;
    assign writes = (c_op <= OP_NEG) && (c_op != OP_MOVSAC);

    // R2: an idle strobe starts a command
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid) |=> busy);

    // R2: busy lasts two cycles only
    p_busy_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    // R2: accumulators only move at the end of a command
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(acc_a) && $stable(acc_b)));

    // R8: no-change opcode
    p_movsac_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACC && c_op == OP_MOVSAC) |=> ($stable(acc_a) && $stable(acc_b)));

    // R5: clear
    p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACC && c_op == OP_CLR && !c_sel_b) |=> (acc_a == '0));

    // R14: the non-target accumulator is untouched
    p_other_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACC && !c_sel_b) |=> $stable(acc_b));

    // R9: normal saturation keeps A inside the 32-bit range
    p_norm_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACC && !c_sel_b && c_sat_a && !c_super && writes)
        |=> ((&acc_a[ACC_W-1:NRM_W-1]) || !(|acc_a[ACC_W-1:NRM_W-1])));

endmodule

bind mac_engine mac_engine_chk #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .busy     (busy),
    .state_q  (state_q),
    .c_op     (cmd_q.op),
    .c_sel_b  (cmd_q.sel_b),
    .c_sat_a  (cmd_q.sat_a),
    .c_super  (cmd_q.super_sat),
    .acc_a    (acc_a),
    .acc_b    (acc_b)
);

// File: tb/mac_engine_tb_top.sv
module mac_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [3:0]    op_code = '0;
    logic          acc_sel = 1'b0;
    logic [DW-1:0] x_in = '0;
    logic [DW-1:0] y_in = '0;
    logic          frac_mode = 1'b0;
    logic          signed_mode = 1'b0;
    logic          sat_en_a = 1'b0;
    logic          sat_en_b = 1'b0;
    logic          sat_super = 1'b0;
    logic          rd_sel = 1'b0;
    logic          rnd_convergent = 1'b0;
    logic          sat_en_rd = 1'b0;
    logic          busy;
    logic [AW-1:0] acc_a;
    logic [AW-1:0] acc_b;
    logic          ov_a_lo, ov_a_hi, ov_b_lo, ov_b_hi;
    logic [DW-1:0] rd_data;

    mac_engine #(.DATA_W(DW), .ACC_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_sel(acc_sel), .x_in(x_in), .y_in(y_in), .frac_mode(frac_mode),
        .signed_mode(signed_mode), .sat_en_a(sat_en_a), .sat_en_b(sat_en_b),
        .sat_super(sat_super), .rd_sel(rd_sel), .rnd_convergent(rnd_convergent),
        .sat_en_rd(sat_en_rd), .busy(busy), .acc_a(acc_a), .acc_b(acc_b),
        .ov_a_lo(ov_a_lo), .ov_a_hi(ov_a_hi), .ov_b_lo(ov_b_lo), .ov_b_hi(ov_b_hi),
        .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    longint m_acc [2];
    bit     m_lo  [2];
    bit     m_hi  [2];

    localparam longint MAX32 = 64'sd2147483647;
    localparam longint MIN32 = -64'sd2147483648;
    localparam longint MAX40 = (64'sd1 <<< 39) - 1;
    localparam longint MIN40 = -(64'sd1 <<< 39);

    function automatic longint ext16(logic [15:0] v, bit sgn);
        if (sgn && v[15]) return longint'(v) - 65536;
        return longint'(v);
    endfunction

    function automatic longint wrap40(longint v);
        longint t = v & ((64'sd1 <<< 40) - 1);
        if (t >= (64'sd1 <<< 39)) t = t - (64'sd1 <<< 40);
        return t;
    endfunction

    function automatic longint exp_rd(longint v, bit conv, bit sat);
        longint q = v >>> 16;
        longint rem = v & 64'hFFFF;
        if (!conv) begin
            if (rem >= 64'h8000) q = q + 1;
        end else begin
            if (rem > 64'h8000) q = q + 1;
            else if (rem == 64'h8000 && (q & 1) != 0) q = q + 1;
        end
        if (sat && q > 32767) return 32767;
        if (sat && q < -32768) return 64'h8000;
        return q & 64'hFFFF;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_apply(int op, bit sel, logic [15:0] x, logic [15:0] y,
                               bit frac, bit sgn, bit sa, bit sb, bit sup);
        longint xe = ext16(x, sgn);
        longint ye = ext16(y, sgn);
        longint p, r, t, o;
        bit wr = 1;
        bit sen = sel ? sb : sa;
        int ti = sel ? 1 : 0;
        if (op == 5 || op == 6) p = (xe - ye) * (xe - ye);
        else if (op == 7) p = xe * xe;
        else p = xe * ye;
        if (frac) p = p * 2;
        t = m_acc[ti];
        o = m_acc[1 - ti];
        case (op)
            0: r = 0;
            1, 5, 7: r = p;
            2: r = -p;
            3, 6: r = t + p;
            4: r = t - p;
            9: r = t + o;
            10: r = t - o;
            11: r = -t;
            default: begin r = t; wr = 0; end
        endcase
        if (wr) begin
            m_lo[ti] = (r > MAX32) || (r < MIN32);
            m_hi[ti] = (r > MAX40) || (r < MIN40);
            if (sen && !sup) r = (r > MAX32) ? MAX32 : ((r < MIN32) ? MIN32 : r);
            else if (sen && sup) r = (r > MAX40) ? MAX40 : ((r < MIN40) ? MIN40 : r);
            else r = wrap40(r);
            m_acc[ti] = r;
        end
    endtask

    task automatic check_state(string req);
        longint ea = m_acc[0] & ((64'sd1 <<< 40) - 1);
        longint eb = m_acc[1] & ((64'sd1 <<< 40) - 1);
        check({req, " acc_a"}, longint'(acc_a), ea);
        check({req, " acc_b"}, longint'(acc_b), eb);
        check({req, " R10 flags"}, longint'({ov_a_lo, ov_a_hi, ov_b_lo, ov_b_hi}),
              longint'({m_lo[0], m_hi[0], m_lo[1], m_hi[1]}));
        for (int s = 0; s < 2; s++) begin
            bit cv = 1'($urandom);
            bit st = 1'($urandom);
            rd_sel = 1'(s);
            rnd_convergent = cv;
            sat_en_rd = st;
            #1;
            check({req, " R11 R12 R13 readout"}, longint'(rd_data),
                  exp_rd(m_acc[s], cv, st));
        end
    endtask

    // called just after a falling edge
    task automatic run_op(int op, bit sel, logic [15:0] x, logic [15:0] y,
                          bit frac, bit sgn, bit sa, bit sb, bit sup, string req);
        op_code = 4'(op); acc_sel = sel; x_in = x; y_in = y;
        frac_mode = frac; signed_mode = sgn;
        sat_en_a = sa; sat_en_b = sb; sat_super = sup;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        x_in = ~x; y_in = ~y; frac_mode = ~frac; signed_mode = ~sgn;
        check("R2 busy during command", longint'(busy), 1);
        @(negedge clk);
        @(negedge clk);
        check("R2 busy cleared", longint'(busy), 0);
        model_apply(op, sel, x, y, frac, sgn, sa, sb, sup);
        check_state(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 2; i++) begin
            m_acc[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", longint'(busy), 0);
        check_state("R1 reset");

        // R4 R9 R10: fractional square of the most negative value, normal clamp
        run_op(1, 0, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, "R4 R9 frac clamp");
        // R3 unsigned operands, integer
        run_op(1, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, "R3 unsigned product");
        // R12 ties on both parities
        run_op(1, 0, 16'h0001, 16'h8000, 0, 0, 0, 0, 0, "R12 even tie");
        run_op(1, 0, 16'h0003, 16'h8000, 0, 0, 0, 0, 0, "R12 odd tie");
        // R6 squared difference and its accumulation
        run_op(5, 1, 16'h8000, 16'h7FFF, 0, 1, 0, 0, 0, "R6 ed");
        run_op(6, 1, 16'h0010, 16'hFFF0, 1, 1, 0, 0, 0, "R6 edac");
        // R5 negated product and subtract
        run_op(2, 0, 16'h1234, 16'h0F00, 1, 1, 0, 0, 0, "R5 mpyn");
        run_op(4, 0, 16'h7FFF, 16'h7FFF, 1, 1, 0, 0, 0, "R5 msc");
        // R8 no-change codes
        run_op(8, 0, 16'h1111, 16'h2222, 0, 1, 1, 1, 1, "R8 movsac");
        run_op(14, 1, 16'h3333, 16'h4444, 0, 1, 1, 1, 1, "R8 reserved code");
        // R7 R9 R10 growth past 40 bits: A wraps, B clamps at 40 bits
        run_op(1, 0, 16'h8000, 16'h8000, 1, 1, 0, 0, 0, "R7 seed a");
        run_op(1, 1, 16'h8000, 16'h8000, 1, 1, 0, 0, 0, "R7 seed b");
        for (int k = 0; k < 14; k++) begin
            run_op(9, 0, 16'hABCD, 16'h1234, 0, 0, 0, 1, 1, "R7 R9 add wrap a");
            run_op(9, 1, 16'hDCBA, 16'h4321, 0, 0, 0, 1, 1, "R7 R9 add super b");
        end
        run_op(11, 1, 16'h0000, 16'h0000, 0, 0, 0, 1, 1, "R7 neg");
        run_op(10, 0, 16'hFFFF, 16'hFFFF, 0, 1, 1, 0, 0, "R7 R14 sub");
        run_op(0, 1, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 0, "R5 clr");

        // R2 strobe while busy is ignored; config sampled at acceptance
        op_code = 4'd3; acc_sel = 1'b0; x_in = 16'h4000; y_in = 16'h4000;
        frac_mode = 1'b1; signed_mode = 1'b1; sat_en_a = 1'b0; sat_en_b = 1'b0;
        sat_super = 1'b0; op_valid = 1'b1;
        @(negedge clk);
        check("R2 busy after accept", longint'(busy), 1);
        op_code = 4'd0; acc_sel = 1'b1; x_in = 16'h0001; sat_en_a = 1'b1;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        check("R2 back to idle", longint'(busy), 0);
        model_apply(3, 0, 16'h4000, 16'h4000, 1, 1, 0, 0, 0);
        check_state("R2 ignored strobe");

        // random mix
        for (int n = 0; n < 300; n++) begin
            run_op(int'($urandom % 16), 1'($urandom), 16'($urandom), 16'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), "R3 R5 R14 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule